// File: doc/BRIEF.md
# Packed Floating-Point Min/Max-Number Unit

This block returns the smaller or the larger of two floating-point values under the IEEE 754-2008 minNum/maxNum rules. If one operand is a quiet NaN and the other is a number, the number wins. In every other case the result matches an ordinary floating-point min or max. The block has two modes. In packed vector mode it works on 64-bit groups, each holding two single-precision or four half-precision lanes, and a width select chooses one group or two. In scalar mode it works on one half-, single- or double-precision value. One cycle after the inputs are accepted, a registered result appears together with two exception flags.

Vector lanes do not use the caller's control bits: they always run with default-NaN and flush-to-zero enabled. Scalar operations follow the default-NaN and flush-to-zero inputs. Each flag is the OR across the active lanes of one operation. The consumer keeps a sticky copy by ORing each flag into its own register.

Top module: `fpmm_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high, and is low otherwise. Reset clears `out_valid`, `result` and both flags to zero.
- R2: `op_min` = 1 selects the minimum and 0 selects the maximum. Ordering is numeric and includes the infinities.
- R3: When exactly one operand is a quiet NaN (all-ones exponent, top fraction bit 1), the result is the other operand.
- R4: A signaling NaN operand (all-ones exponent, top fraction bit 0, nonzero fraction) raises `flag_ioc`. The result is that NaN with its top fraction bit set, or the default NaN when default-NaN is active. A signaling NaN beats a quiet NaN, and if neither beats the other, operand A wins. Two quiet NaNs give A, or the default NaN when default-NaN is active.
- R5: For min, -0 is smaller than +0. For max, +0 is larger than -0. This holds in either operand order.
- R6: With flush-to-zero active, a denormal input is replaced by a zero of its own sign before the comparison, and `flag_idc` is raised. With it inactive, denormals are compared exactly and `flag_idc` stays low.
- R7: The default NaN is 0x7E00 for half, 0x7FC00000 for single and 0x7FF8000000000000 for double precision.
- R8: Scalar mode is selected by `scalar_mode` = 1, and `scalar_size` picks the width: 1 = half, 2 = single, 3 = double, 0 = single. The scalar result sits in the low bits of `result`. All result bits above it are zero, including the upper 16 bits of the 32-bit word that holds a half-precision result.
- R9: In vector mode, `elem_half` = 0 gives 32-bit lanes and 1 gives 16-bit lanes, with lane i at bits [i*w +: w]. `wide` = 1 processes bits 127:0. `wide` = 0 processes bits 63:0 and forces `result[127:64]` to zero.
- R10: Vector mode ignores `ctl_dn` and `ctl_fz` and behaves as if both were 1.
- R11: The flags are the OR over active lanes only and are registered together with `result`. Operands in inactive lanes raise no flag, and both flags are low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opa | input | 128 | Operand A bus |
| opb | input | 128 | Operand B bus |
| op_min | input | 1 | 1 = minimum, 0 = maximum |
| scalar_mode | input | 1 | 1 = scalar, 0 = packed vector |
| scalar_size | input | 2 | Scalar width code (1 half, 2 single, 3 double, 0 single) |
| elem_half | input | 1 | Vector lane width: 0 = 32-bit, 1 = 16-bit |
| wide | input | 1 | Vector width: 1 = 128-bit, 0 = 64-bit |
| ctl_dn | input | 1 | Default-NaN enable (scalar only) |
| ctl_fz | input | 1 | Flush-to-zero enable (scalar only) |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result bus |
| flag_ioc | output | 1 | Invalid operation for this result |
| flag_idc | output | 1 | Input denormal flushed for this result |

## Verification
The bench covers each NaN case:
- Quiet NaN paired with a number, where a design that propagated the NaN would return the NaN.
- Quiet NaN paired with a signaling NaN, where a design with the wrong priority would return the quieted quiet operand.
- Scalar signaling NaN with default-NaN off, where the result must keep its payload.

Signed zeros are applied in both operand orders, because a plain magnitude compare returns whichever zero sits in operand A. Denormals are applied with flushing on and off, and in vector lanes while the caller's control bits are off. A block that leaked those bits into vector lanes would return the denormal instead of a zero. Operands sitting in upper or inactive lanes would then show up as stray result bits or spurious flags.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  typedef enum logic [1:0] {
    SZ_RSV  = 2'd0,
    SZ_HALF = 2'd1,
    SZ_SGL  = 2'd2,
    SZ_DBL  = 2'd3
  } scalar_sz_e;

  localparam int H_EXP = 5;
  localparam int H_FRC = 10;
  localparam int S_EXP = 8;
  localparam int S_FRC = 23;
  localparam int D_EXP = 11;
  localparam int D_FRC = 52;
endpackage

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] a,
  input  logic [EW+FW:0] b,
  input  logic           is_min,
  input  logic           dn,
  input  logic           fz,
  output logic [EW+FW:0] r,
  output logic           ioc,
  output logic           idc
);
  localparam int W = 1 + EW + FW;
  localparam logic [W-1:0] QBIT   = {{(EW+1){1'b0}}, 1'b1, {(FW-1){1'b0}}};
  localparam logic [W-1:0] DEFNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  function automatic logic f_nan(input logic [W-1:0] x);
    return (&x[W-2:FW]) && (|x[FW-1:0]);
  endfunction

  function automatic logic f_snan(input logic [W-1:0] x);
    return f_nan(x) && !x[FW-1];
  endfunction

  function automatic logic f_sub(input logic [W-1:0] x);
    return (~|x[W-2:FW]) && (|x[FW-1:0]);
  endfunction

  function automatic logic [W-1:0] f_flush(input logic [W-1:0] x);
    return {x[W-1], {(W-1){1'b0}}};
  endfunction

  // strict numeric less-than, -0 below +0
  function automatic logic f_less(input logic [W-1:0] x, input logic [W-1:0] y);
    if (x[W-1] != y[W-1]) return x[W-1];
    else if (!x[W-1])     return x[W-2:0] < y[W-2:0];
    else                  return x[W-2:0] > y[W-2:0];
  endfunction

  logic [W-1:0] ax, bx;
  logic a_s, b_s, a_q, b_q;

  always_comb begin
    ax  = (fz && f_sub(a)) ? f_flush(a) : a;
    bx  = (fz && f_sub(b)) ? f_flush(b) : b;
    idc = fz && (f_sub(a) || f_sub(b));
    a_s = f_snan(a);
    b_s = f_snan(b);
    a_q = f_nan(a) && !a_s;
    b_q = f_nan(b) && !b_s;
    ioc = a_s || b_s;
    if (a_s)              r = dn ? DEFNAN : (a | QBIT);
    else if (b_s)         r = dn ? DEFNAN : (b | QBIT);
    else if (a_q && b_q)  r = dn ? DEFNAN : a;
    else if (a_q)         r = bx;
    else if (b_q)         r = ax;
    else                  r = (f_less(ax, bx) == is_min) ? ax : bx;
  end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit #(
  parameter int VEC_W   = 128,
  parameter int GROUP_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic             op_min,
  input  logic             scalar_mode,
  input  logic [1:0]       scalar_size,
  input  logic             elem_half,
  input  logic             wide,
  input  logic             ctl_dn,
  input  logic             ctl_fz,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             flag_ioc,
  output logic             flag_idc
);
  import fpmm_pkg::*;

  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;
  localparam int N64 = VEC_W / 64;
  localparam int G16 = GROUP_W / 16;
  localparam int G32 = GROUP_W / 32;

  logic dn_eff, fz_eff, sz_h, sz_s, sz_d;
  assign dn_eff = scalar_mode ? ctl_dn : 1'b1;
  assign fz_eff = scalar_mode ? ctl_fz : 1'b1;
  assign sz_h   = (scalar_sz_e'(scalar_size) == SZ_HALF);
  assign sz_d   = (scalar_sz_e'(scalar_size) == SZ_DBL);
  assign sz_s   = !sz_h && !sz_d;

  logic [15:0] r16 [N16];
  logic [31:0] r32 [N32];
  logic [63:0] r64 [N64];
  logic [N16-1:0] ioc16, idc16, act16;
  logic [N32-1:0] ioc32, idc32, act32;
  logic [N64-1:0] ioc64, idc64, act64;

  for (genvar i = 0; i < N16; i++) begin : g_h
    fpmm_lane #(.EW(H_EXP), .FW(H_FRC)) u_lane (
      .a(opa[16*i +: 16]), .b(opb[16*i +: 16]), .is_min(op_min),
      .dn(dn_eff), .fz(fz_eff), .r(r16[i]), .ioc(ioc16[i]), .idc(idc16[i]));
    assign act16[i] = scalar_mode ? (sz_h && i == 0) : (elem_half && (wide || i < G16));
  end

  for (genvar i = 0; i < N32; i++) begin : g_s
    fpmm_lane #(.EW(S_EXP), .FW(S_FRC)) u_lane (
      .a(opa[32*i +: 32]), .b(opb[32*i +: 32]), .is_min(op_min),
      .dn(dn_eff), .fz(fz_eff), .r(r32[i]), .ioc(ioc32[i]), .idc(idc32[i]));
    assign act32[i] = scalar_mode ? (sz_s && i == 0) : (!elem_half && (wide || i < G32));
  end

  for (genvar i = 0; i < N64; i++) begin : g_d
    fpmm_lane #(.EW(D_EXP), .FW(D_FRC)) u_lane (
      .a(opa[64*i +: 64]), .b(opb[64*i +: 64]), .is_min(op_min),
      .dn(dn_eff), .fz(fz_eff), .r(r64[i]), .ioc(ioc64[i]), .idc(idc64[i]));
    assign act64[i] = scalar_mode && sz_d && i == 0;
  end

  logic [VEC_W-1:0] res_n;
  logic             ioc_n, idc_n;

  always_comb begin
    res_n = '0;
    for (int i = 0; i < N16; i++) if (act16[i]) res_n[16*i +: 16] = r16[i];
    for (int i = 0; i < N32; i++) if (act32[i]) res_n[32*i +: 32] = r32[i];
    for (int i = 0; i < N64; i++) if (act64[i]) res_n[64*i +: 64] = r64[i];
    ioc_n = |{ioc16 & act16, ioc32 & act32, ioc64 & act64};
    idc_n = |{idc16 & act16, idc32 & act32, idc64 & act64};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_ioc  <= 1'b0;
      flag_idc  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_n;
        flag_ioc <= ioc_n;
        flag_idc <= idc_n;
      end else begin
        flag_ioc <= 1'b0;
        flag_idc <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpmm_chk.sv
module fpmm_chk #(
  parameter int VEC_W = 128,
  parameter int N16   = 8,
  parameter int N32   = 4,
  parameter int N64   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             scalar_mode,
  input logic [1:0]       scalar_size,
  input logic             wide,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             flag_ioc,
  input logic             flag_idc,
  input logic [N16-1:0]   act16,
  input logic [N32-1:0]   act32,
  input logic [N64-1:0]   act64
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!flag_ioc && !flag_idc)); // R11
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_mode && scalar_size == 2'd1) |=> (result[VEC_W-1:16] == '0)); // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[VEC_W-1:64] == '0)); // R9
  AST_SCALAR_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    scalar_mode |-> ($countones({act16, act32, act64}) == 1)); // R8
  AST_VEC_NO_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    !scalar_mode |-> (act64 == '0)); // R9
  AST_SGL_IOC_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_mode && scalar_size == 2'd2) |=>
      (!flag_ioc || (&result[30:22]))); // R4
endmodule

bind fpmm_unit fpmm_chk #(.VEC_W(VEC_W), .N16(N16), .N32(N32), .N64(N64)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scalar_mode(scalar_mode),
  .scalar_size(scalar_size), .wide(wide), .out_valid(out_valid), .result(result),
  .flag_ioc(flag_ioc), .flag_idc(flag_idc), .act16(act16), .act32(act32), .act64(act64));

// File: tb/sim_fpmm_unit.sv
`timescale 1ns/1ps
module sim_fpmm_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] opa = '0, opb = '0;
  logic         op_min = 1'b0, scalar_mode = 1'b0, elem_half = 1'b0, wide = 1'b0;
  logic [1:0]   scalar_size = 2'd0;
  logic         ctl_dn = 1'b0, ctl_fz = 1'b0;
  logic         out_valid, flag_ioc, flag_idc;
  logic [127:0] result;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  fpmm_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .op_min(op_min), .scalar_mode(scalar_mode), .scalar_size(scalar_size),
    .elem_half(elem_half), .wide(wide), .ctl_dn(ctl_dn), .ctl_fz(ctl_fz),
    .out_valid(out_valid), .result(result), .flag_ioc(flag_ioc), .flag_idc(flag_idc));

  task automatic chk(input string req, input logic [127:0] er, input logic ei, input logic ed);
    checks++;
    if (out_valid !== 1'b1 || result !== er || flag_ioc !== ei || flag_idc !== ed) begin
      fails++;
      $display("FAIL %s: got v=%b r=%h ioc=%b idc=%b exp v=1 r=%h ioc=%b idc=%b",
               req, out_valid, result, flag_ioc, flag_idc, er, ei, ed);
    end
  endtask

  // drive one operation at a negedge, sample the registered result one cycle later
  task automatic run(input logic [127:0] a, input logic [127:0] b, input logic mn,
                     input logic sc, input logic [1:0] sz, input logic eh, input logic wd,
                     input logic dn, input logic fz);
    @(negedge clk);
    opa = a; opb = b; op_min = mn; scalar_mode = sc; scalar_size = sz;
    elem_half = eh; wide = wd; ctl_dn = dn; ctl_fz = fz; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sgl(input logic [31:0] a, input logic [31:0] b, input logic mn,
                     input logic dn, input logic fz, input logic [31:0] e,
                     input logic ei, input logic ed, input string req);
    run({96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, a}, {96'h1, b}, mn, 1'b1, 2'd2, 1'b0, 1'b1, dn, fz);
    chk(req, {96'h0, e}, ei, ed);
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flag_ioc !== 1'b0 || flag_idc !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got v=%b r=%h ioc=%b idc=%b exp all zero",
               out_valid, result, flag_ioc, flag_idc);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || flag_ioc !== 1'b0 || flag_idc !== 1'b0) begin
      fails++;
      $display("FAIL R1/R11 idle: got v=%b ioc=%b idc=%b exp 0 0 0", out_valid, flag_ioc, flag_idc);
    end
  endtask

  task automatic t_order();
    sgl(32'h3F800000, 32'h40000000, 1'b1, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R2 min");
    sgl(32'h3F800000, 32'h40000000, 1'b0, 1'b0, 1'b0, 32'h40000000, 1'b0, 1'b0, "R2 max");
    sgl(32'h40000000, 32'hBF800000, 1'b1, 1'b0, 1'b0, 32'hBF800000, 1'b0, 1'b0, "R2 neg min");
    sgl(32'h7F800000, 32'h3F800000, 1'b0, 1'b0, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R2 +inf max");
    sgl(32'h3F800000, 32'hFF800000, 1'b1, 1'b0, 1'b0, 32'hFF800000, 1'b0, 1'b0, "R2 -inf min");
  endtask

  task automatic t_qnan_num();
    sgl(32'h7FC00000, 32'h3F800000, 1'b1, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R3 qnan A");
    sgl(32'h3F800000, 32'h7FC00000, 1'b0, 1'b1, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R3 qnan B");
  endtask

  task automatic t_snan();
    sgl(32'h7F800001, 32'h3F800000, 1'b1, 1'b0, 1'b0, 32'h7FC00001, 1'b1, 1'b0, "R4 snan quiet");
    sgl(32'h7F800001, 32'h3F800000, 1'b1, 1'b1, 1'b0, 32'h7FC00000, 1'b1, 1'b0, "R4 R7 snan dn");
    sgl(32'h7FC00005, 32'h7F800002, 1'b1, 1'b0, 1'b0, 32'h7FC00002, 1'b1, 1'b0, "R4 snan priority");
    sgl(32'h7FC00005, 32'h7FC00007, 1'b0, 1'b0, 1'b0, 32'h7FC00005, 1'b0, 1'b0, "R4 two qnan");
    sgl(32'h7FC00005, 32'h7FC00007, 1'b0, 1'b1, 1'b0, 32'h7FC00000, 1'b0, 1'b0, "R4 two qnan dn");
  endtask

  task automatic t_zero();
    sgl(32'h00000000, 32'h80000000, 1'b1, 1'b0, 1'b0, 32'h80000000, 1'b0, 1'b0, "R5 min +0,-0");
    sgl(32'h80000000, 32'h00000000, 1'b1, 1'b0, 1'b0, 32'h80000000, 1'b0, 1'b0, "R5 min -0,+0");
    sgl(32'h00000000, 32'h80000000, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, "R5 max +0,-0");
    sgl(32'h80000000, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, "R5 max -0,+0");
  endtask

  task automatic t_flush();
    sgl(32'h80000001, 32'h00000000, 1'b1, 1'b0, 1'b0, 32'h80000001, 1'b0, 1'b0, "R6 no flush");
    sgl(32'h80000001, 32'h00000000, 1'b1, 1'b0, 1'b1, 32'h80000000, 1'b0, 1'b1, "R6 flush");
  endtask

  task automatic t_scalar_sizes();
    run({112'hFFFF, 16'h3C00}, {112'hABCD, 16'h4000}, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 half min", {112'h0, 16'h3C00}, 1'b0, 1'b0);
    run({112'h0, 16'h7D00}, {112'h0, 16'h3C00}, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 half snan quiet", {112'h0, 16'h7F00}, 1'b1, 1'b0);
    run({112'h0, 16'h7D00}, {112'h0, 16'h3C00}, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 half default nan", {112'h0, 16'h7E00}, 1'b1, 1'b0);
    run({64'hFFFF_FFFF_FFFF_FFFF, 64'h3FF0000000000000}, {64'h5, 64'h4000000000000000},
        1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 double max", {64'h0, 64'h4000000000000000}, 1'b0, 1'b0);
    run({64'h0, 64'h7FF8000000000000}, {64'h0, 64'h3FF0000000000000},
        1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 R8 double qnan", {64'h0, 64'h3FF0000000000000}, 1'b0, 1'b0);
    run({64'h0, 64'h7FF0000000000001}, {64'h0, 64'h3FF0000000000000},
        1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 double default nan", {64'h0, 64'h7FF8000000000000}, 1'b1, 1'b0);
    run({96'hFFFF, 32'h40400000}, {96'h0, 32'h40000000}, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 code 0 single", {96'h0, 32'h40000000}, 1'b0, 1'b0);
  endtask

  task automatic t_vec32();
    run({64'hDEADBEEF_DEADBEEF, 32'h7FC00000, 32'h3F800000},
        {64'h12345678_12345678, 32'hBF800000, 32'h40000000},
        1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 vec32 narrow", {64'h0, 32'hBF800000, 32'h3F800000}, 1'b0, 1'b0);
    run({32'h40400000, 32'h7F800000, 32'h00000001, 32'h7F800001},
        {32'h40000000, 32'hFF800000, 32'h80000000, 32'h3F800000},
        1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 R10 vec32 wide", {32'h40000000, 32'hFF800000, 32'h80000000, 32'h7FC00000}, 1'b1, 1'b1);
  endtask

  task automatic t_vec16();
    run({16'h7D00, 16'hFC00, 16'h7C00, 16'h0001, 16'h8000, 16'h0000, 16'h7E00, 16'h3C00},
        {16'h3C00, 16'h3C00, 16'h7BFF, 16'h8000, 16'h0000, 16'h8000, 16'hC000, 16'h4000},
        1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 R10 vec16 wide max",
        {16'h7E00, 16'h3C00, 16'h7C00, 16'h0000, 16'h0000, 16'h0000, 16'hC000, 16'h4000}, 1'b1, 1'b1);
    run({16'h0, 16'h0, 16'h7D00, 16'h0, 16'h0, 16'h0, 16'h0, 16'h3C00},
        {16'h0, 16'h0, 16'h3C00, 16'h0, 16'h0, 16'h0, 16'h0, 16'h4000},
        1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 R11 vec16 narrow inactive snan", {112'h0, 16'h3C00}, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_order();
    t_idle();
    t_qnan_num();
    t_snan();
    t_zero();
    t_flush();
    t_scalar_sizes();
    t_vec32();
    t_vec16();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule